// File: doc/BRIEF.md
# Low-power halt and sleep controller

This block sequences the two low-power modes of a CPU. A halt request stops only the CPU clock, so timers, serial logic and the other peripherals keep running. A sleep request stops the CPU clock and the peripheral clocks and switches the oscillator off. The controller decides which pending interrupts may end each mode and gives the CPU an explicit resume pulse. The CPU exception sequence then services the interrupt that caused the wake.

From halt, any pending interrupt wakes the part at once. From sleep, only the input-port interrupt can wake it. The oscillator is switched back on first. The CPU stays held until a fixed number of ticks of the slow oscillator has been counted, which gives the oscillator time to settle. An asynchronous reset returns the controller to normal running from any state and clears the settling count.

Top module: `lpm_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces the run state at once. In reset and on release, cpu_clk_en_o, per_clk_en_o and osc_en_o are 1 and wake_o is 0.
- R2: In run, halt_req_i high at a clock edge enters halt. From the next cycle the outputs are cpu_clk_en_o=0, per_clk_en_o=1 and osc_en_o=1.
- R3: In run, sleep_req_i high at a clock edge enters sleep, and all three enables are 0 from the next cycle. When both requests are high in the same cycle, sleep is taken.
- R4: In halt, a 1 on any bit of irq_pend_i or on port_irq_i at a clock edge returns the controller to run, with all three enables at 1 from the next cycle. Without such an interrupt, halt is held.
- R5: In sleep, irq_pend_i has no effect. Only port_irq_i high at a clock edge leaves sleep, and it enters the stabilize state: osc_en_o=1, cpu_clk_en_o=0, per_clk_en_o=0.
- R6: In stabilize, the controller counts clock cycles in which osc_tick_i is 1. It returns to run in the cycle after the STAB_CYCLES-th such tick (8192 by default). Interrupt inputs are ignored during this wait.
- R7: wake_o is 1 for exactly one cycle: the first run cycle after leaving halt or stabilize. It is never 1 after reset or while running, whatever the interrupt inputs are.
- R8: halt_req_i and sleep_req_i are ignored in halt, sleep and stabilize.
- R9: A reset during stabilize discards the partial count. The next stabilize wait takes the full STAB_CYCLES ticks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock (free running) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Request to enter halt |
| sleep_req_i | input | 1 | Request to enter sleep |
| irq_pend_i | input | NUM_SRC | Enabled, pending interrupt per source |
| port_irq_i | input | 1 | Enabled, pending input-port interrupt |
| osc_tick_i | input | 1 | One-cycle strobe per slow oscillator period |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| wake_o | output | 1 | One-cycle pulse that starts exception processing |

## Verification
The bench walks every interrupt source, and the input-port line, through a halt wake. It then drives each non-port source and each request into sleep, where a design that qualified wake sources badly would leave sleep on the wrong interrupt or switch the clocks back on. The settling wait is checked on both sides of its boundary: a counter that is off by one would release the CPU a tick early or late. Interrupts and requests are kept active during the wait to show that they are ignored. A reset part-way through the count is followed by a second full wait, which catches a counter that keeps its old value across reset and so ends the second wait early.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_STAB  = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] irq_pend_i,
  input  logic               port_irq_i,
  output logic               halt_wake_o,
  output logic               sleep_wake_o
);
  // halt: any source; sleep: input port only
  assign halt_wake_o  = (|irq_pend_i) | port_irq_i;
  assign sleep_wake_o = port_irq_i;
endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
  parameter int STAB_CYCLES = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R6
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_req_i,
  input  logic       sleep_req_i,
  input  logic       halt_wake_i,
  input  logic       sleep_wake_i,
  input  logic       stab_done_i,
  output lpm_state_e state_o,
  output logic       stab_clr_o,
  output logic       stab_run_o,
  output logic       wake_o
);
  lpm_state_e state_q, state_d;
  logic       wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req_i)      state_d = ST_SLEEP;
        else if (halt_req_i)  state_d = ST_HALT;
      end
      ST_HALT: begin
        if (halt_wake_i) begin
          state_d = ST_RUN;
          wake_d  = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (sleep_wake_i)     state_d = ST_STAB;
      end
      ST_STAB: begin
        if (stab_done_i) begin
          state_d = ST_RUN;
          wake_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign state_o    = state_q;
  assign wake_o     = wake_q;
  assign stab_clr_o = (state_q == ST_SLEEP);
  assign stab_run_o = (state_q == ST_STAB);

  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q); // R7
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !sleep_wake_i) |=> (state_q == ST_SLEEP)); // R5
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && !halt_wake_i) |=> (state_q == ST_HALT)); // R8
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STAB_CYCLES = 8192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_req_i,
  input  logic               sleep_req_i,
  input  logic [NUM_SRC-1:0] irq_pend_i,
  input  logic               port_irq_i,
  input  logic               osc_tick_i,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               osc_en_o,
  output logic               wake_o
);
  lpm_state_e state;
  logic halt_wake, sleep_wake, stab_done, stab_clr, stab_run;

  lpm_wake_qual #(.NUM_SRC(NUM_SRC)) u_qual (
    .irq_pend_i  (irq_pend_i),
    .port_irq_i  (port_irq_i),
    .halt_wake_o (halt_wake),
    .sleep_wake_o(sleep_wake)
  );

  lpm_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (stab_clr),
    .run_i (stab_run),
    .tick_i(osc_tick_i),
    .done_o(stab_done)
  );

  lpm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_req_i  (halt_req_i),
    .sleep_req_i (sleep_req_i),
    .halt_wake_i (halt_wake),
    .sleep_wake_i(sleep_wake),
    .stab_done_i (stab_done),
    .state_o     (state),
    .stab_clr_o  (stab_clr),
    .stab_run_o  (stab_run),
    .wake_o      (wake_o)
  );

  always_comb begin
    unique case (state)
      ST_RUN:   {cpu_clk_en_o, per_clk_en_o, osc_en_o} = 3'b111;
      ST_HALT:  {cpu_clk_en_o, per_clk_en_o, osc_en_o} = 3'b011;
      ST_SLEEP: {cpu_clk_en_o, per_clk_en_o, osc_en_o} = 3'b000;
      ST_STAB:  {cpu_clk_en_o, per_clk_en_o, osc_en_o} = 3'b001;
      default:  {cpu_clk_en_o, per_clk_en_o, osc_en_o} = 3'b111;
    endcase
  end

  AST_WAKE_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cpu_clk_en_o && per_clk_en_o && osc_en_o)); // R7
  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !wake_o && sleep_req_i) |=> !per_clk_en_o); // R3
  AST_DONE_IN_STAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_done |-> (osc_en_o && !per_clk_en_o)); // R6
  AST_NO_STRAY_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !port_irq_i) |=> !osc_en_o); // R5
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int NS   = 8;
  localparam int STAB = 8192;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_req = 1'b0, sleep_req = 1'b0, port_irq = 1'b0, tick = 1'b0;
  logic [NS-1:0] irq = '0;
  logic cpu_en, per_en, osc_en, wake;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NUM_SRC(NS), .STAB_CYCLES(STAB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .halt_req_i(halt_req), .sleep_req_i(sleep_req),
    .irq_pend_i(irq), .port_irq_i(port_irq), .osc_tick_i(tick),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en), .wake_o(wake)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected {cpu,per,osc,wake}
  task automatic chk(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {cpu_en, per_en, osc_en, wake};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step();
      tick = 1'b0; step();
    end
  endtask

  task automatic enter_stab();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R3 sleep entry", 4'b0000);
    port_irq = 1'b1; step(); port_irq = 1'b0;
    chk("R5 port wake to stabilize", 4'b0010);
  endtask

  initial begin
    step(2);
    chk("R1 in reset", 4'b1110);
    rst_ni = 1'b1; step();
    chk("R1 after release", 4'b1110);

    irq = '1; port_irq = 1'b1; step(3);
    chk("R7 no wake while running", 4'b1110);
    irq = '0; port_irq = 1'b0;

    // halt wake sweep: bits 0..NS-1, then input port
    for (int s = 0; s <= NS; s++) begin
      halt_req = 1'b1; step(); halt_req = 1'b0;
      chk("R2 halt entry", 4'b0110);
      step(3);
      chk("R4 halt held", 4'b0110);
      if (s < NS) irq[s] = 1'b1; else port_irq = 1'b1;
      step();
      chk("R4 halt wake", 4'b1111);
      irq = '0; port_irq = 1'b0; step();
      chk("R7 pulse one cycle", 4'b1110);
    end

    // requests ignored in halt
    halt_req = 1'b1; step(); halt_req = 1'b0;
    sleep_req = 1'b1; step(2); sleep_req = 1'b0;
    chk("R8 sleep ignored in halt", 4'b0110);
    irq[0] = 1'b1; step(); irq = '0;
    chk("R4 wake after ignored req", 4'b1111);
    step();

    // both requests: sleep wins
    halt_req = 1'b1; sleep_req = 1'b1; step(); halt_req = 1'b0; sleep_req = 1'b0;
    chk("R3 sleep priority", 4'b0000);
    for (int s = 0; s < NS; s++) begin
      irq = '0; irq[s] = 1'b1; step();
      chk("R5 source ignored in sleep", 4'b0000);
    end
    irq = '0;
    halt_req = 1'b1; step(2); halt_req = 1'b0;
    chk("R8 halt ignored in sleep", 4'b0000);
    port_irq = 1'b1; step(); port_irq = 1'b0;
    chk("R5 stabilize entry", 4'b0010);

    // stabilize with interrupts and requests held, then released
    irq = '1; halt_req = 1'b1; sleep_req = 1'b1;
    ticks(1);
    chk("R6 one tick", 4'b0010);
    ticks(99);
    chk("R8 requests ignored in stabilize", 4'b0010);
    irq = '0; halt_req = 1'b0; sleep_req = 1'b0;
    step(5);
    chk("R6 no count without tick", 4'b0010);
    ticks(STAB - 101);
    chk("R6 held at tick 8191", 4'b0010);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R6 release at last tick", 4'b1111);
    step();
    chk("R7 pulse cleared", 4'b1110);

    // reset mid-count
    enter_stab();
    ticks(5000);
    chk("R6 mid count", 4'b0010);
    rst_ni = 1'b0; #1;
    chk("R1 async reset", 4'b1110);
    step(); rst_ni = 1'b1; step();
    chk("R9 run after reset", 4'b1110);
    enter_stab();
    ticks(STAB - 1);
    chk("R9 full wait after reset", 4'b0010);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R9 release after full wait", 4'b1111);
    step();
    chk("R7 pulse cleared again", 4'b1110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule